// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block chooses which request the processor services next. It holds one control entry for each interrupt source: a pending flag, an enable, a 4-bit level and a 2-bit group sub-priority. It also holds a sticky flag for each synchronous fault condition. The CPU marks each instruction-cycle boundary with `cyc_end`. At that boundary the block compares the highest-ranked pending interrupt with the current CPU level and the global enable. It then issues a one-cycle acknowledge that carries a trap number, a vector address and a level.

There are three kinds of event. Hardware faults share a single trap number, and they are taken whatever the enable and the CPU level are. A software trap instruction names its trap number directly. Interrupt sources go through a two-level ranking: the level decides first, and the group field breaks ties between sources on the same level. The CPU level register sits inside the block. An accepted event updates it, and the CPU can also load it directly.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, `ack` is 0, `cpu_lvl` is 0, and every pending flag and fault flag is 0.
- R2: A source can compete only if it is pending, its enable is 1 and its level is non-zero. The winner is the competitor with the largest key {level, group}. When two competitors have equal keys, the lower source index wins.
- R3: An interrupt winner is accepted only at an edge where `cyc_end` is 1 and `glob_ien` is 1, and only if its level is strictly greater than `cpu_lvl`. `ack` is high for exactly the one cycle after that edge.
- R4: When an interrupt from source i is accepted, the block does four things. It sets `ack_trapno` to `INT_BASE`+i. It sets `ack_lvl` to the source's level. It loads `cpu_lvl` with that level. It clears the pending flag of source i at the same edge. A `req_set` for source i at that same edge leaves the source pending.
- R5: A source that is disabled, at level 0, or that loses the arbitration is not acknowledged, and it stays pending.
- R6: A 1 on bit k of `fault_set` sets sticky flag k. The flag holds until bit k of `fault_clr` is seen, and a set on the same edge wins over the clear. Each set arms one fault trap, taken at the next boundary whatever `glob_ien` and `cpu_lvl` are. The fault trap reports trap number 0x0A, vector 0x000028 and level 15, and it loads 15 into `cpu_lvl`. Each arming is taken only once.
- R7: A software trap is `sw_trap` high at a boundary. It is taken whatever `glob_ien` and `cpu_lvl` are, with `ack_trapno` equal to `sw_trap_num`. `cpu_lvl` is left unchanged, and `ack_lvl` reports the current `cpu_lvl`. Numbers 0x0B to 0x0F are reserved and produce no acknowledge.
- R8: At one boundary a fault trap wins over a software trap, and a software trap wins over an interrupt. A losing interrupt stays pending.
- R9: `ack_vec` equals `ack_trapno` times 4, zero-extended to `VEC_W` bits. The range is 0x000000 to 0x0001FC.
- R10: `cpu_lvl_we` loads `cpu_lvl_wdata` into `cpu_lvl`. If an accept that changes the level happens at the same edge, the accept's level takes its place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_end | input | 1 | Instruction-cycle boundary strobe |
| glob_ien | input | 1 | Global interrupt enable |
| cfg_we | input | 1 | Write strobe for a source control entry |
| cfg_idx | input | IDX_W | Source index to write |
| cfg_en | input | 1 | Enable value to write |
| cfg_lvl | input | 4 | Level value to write |
| cfg_grp | input | 2 | Group value to write |
| req_set | input | NSRC | Per-source request pulses |
| cpu_lvl_we | input | 1 | Direct load strobe for the CPU level |
| cpu_lvl_wdata | input | 4 | CPU level to load |
| fault_set | input | NFAULT | Fault condition pulses |
| fault_clr | input | NFAULT | Fault flag clear pulses |
| sw_trap | input | 1 | Software trap request at this boundary |
| sw_trap_num | input | 7 | Software trap number |
| ack | output | 1 | One-cycle acknowledge |
| ack_trapno | output | 7 | Trap number of the accepted event |
| ack_vec | output | VEC_W | Vector address of the accepted event |
| ack_lvl | output | 4 | Level of the accepted event |
| cpu_lvl | output | 4 | Current CPU priority level |
| req_pend | output | NSRC | Per-source pending flags |
| fault_flags | output | NFAULT | Sticky fault flags |

## Verification
The bench builds the block with NSRC=6. This value is not a power of two, so the index field has unused codes, and a tree of six sources still allows equal-key ties and a disabled top-level source. NFAULT=5 gives each fault condition its own flag, and INT_BASE=16 puts interrupt trap numbers just above the reserved window. That allows software traps on either side of the window, and software traps that share numbers with interrupts. Random configurations, compared against a reference maximum search, reach key collisions and the case where the winner's level equals the CPU level.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int LVL_W  = 4;
    localparam int GRP_W  = 2;
    localparam int TNUM_W = 7;
    localparam logic [TNUM_W-1:0] FAULT_TNUM = 7'h0A;
    localparam logic [TNUM_W-1:0] RSV_LO     = 7'h0B;
    localparam logic [TNUM_W-1:0] RSV_HI     = 7'h0F;
    localparam logic [LVL_W-1:0]  TOP_LVL    = '1;

    typedef struct packed {
        logic             en;
        logic [LVL_W-1:0] lvl;
        logic [GRP_W-1:0] grp;
    } src_cfg_t;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_FAULT = 2'd1,
        EV_SOFT  = 2'd2,
        EV_IRQ   = 2'd3
    } ev_kind_t;
endpackage

// File: rtl/irq_srcregs.sv
module irq_srcregs
    import irq_arb_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic                  cfg_en,
    input  logic [LVL_W-1:0]      cfg_lvl,
    input  logic [GRP_W-1:0]      cfg_grp,
    input  logic [NSRC-1:0]       req_set,
    input  logic [NSRC-1:0]       req_clr,
    output src_cfg_t [NSRC-1:0]   cfg_o,
    output logic [NSRC-1:0]       pend_o
);
    typedef struct packed {
        src_cfg_t [NSRC-1:0] cfg;
        logic [NSRC-1:0]     pend;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (cfg_we && (int'(cfg_idx) < NSRC)) begin
            regs_d.cfg[cfg_idx] = '{en: cfg_en, lvl: cfg_lvl, grp: cfg_grp};
        end
        regs_d.pend = (regs_q.pend & ~req_clr) | req_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign cfg_o  = regs_q.cfg;
    assign pend_o = regs_q.pend;

    // R4: an acknowledged source without a fresh request drops its flag
    p_pend_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_clr != '0) && ((req_clr & req_set) == '0)) |=> ((pend_o & $past(req_clr)) == '0));
    // R5: a flag only leaves through a clear
    p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o != '0) |=> ((pend_o & $past(pend_o & ~req_clr)) == $past(pend_o & ~req_clr)));
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_arb_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  src_cfg_t [NSRC-1:0] cfg_i,
    input  logic [NSRC-1:0]     pend_i,
    output logic                win_valid,
    output logic [IDX_W-1:0]    win_idx,
    output logic [LVL_W-1:0]    win_lvl
);
    localparam int KEY_W = LVL_W + GRP_W;

    logic [KEY_W-1:0] best_key;
    logic [NSRC-1:0]  cand;

    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        best_key  = '0;
        win_lvl   = '0;
        for (int i = 0; i < NSRC; i++) begin
            cand[i] = pend_i[i] && cfg_i[i].en && (cfg_i[i].lvl != '0);
            if (cand[i] && (!win_valid || ({cfg_i[i].lvl, cfg_i[i].grp} > best_key))) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                best_key  = {cfg_i[i].lvl, cfg_i[i].grp};
                win_lvl   = cfg_i[i].lvl;
            end
        end
    end

    // R2: a chosen source is always a legal competitor
    always_comb begin
        if (win_valid) begin
            a_win_legal_r2: assert (pend_i[win_idx] && cfg_i[win_idx].en && (win_lvl != '0));
        end
    end
endmodule

// File: rtl/irq_faults.sv
module irq_faults #(
    parameter int NFAULT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFAULT-1:0] fault_set,
    input  logic [NFAULT-1:0] fault_clr,
    input  logic              take,
    output logic [NFAULT-1:0] flags_o,
    output logic              armed_o
);
    typedef struct packed {
        logic [NFAULT-1:0] flags;
        logic              armed;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d       = flt_q;
        flt_d.flags = (flt_q.flags & ~fault_clr) | fault_set;
        flt_d.armed = (flt_q.armed & ~take) | (|fault_set);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign flags_o = flt_q.flags;
    assign armed_o = flt_q.armed;

    // R6: a flag never drops without its own clear
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o != '0) |=> ((flags_o & $past(flags_o & ~fault_clr)) == $past(flags_o & ~fault_clr)));
    // R6: one trap per arming
    p_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (fault_set == '0)) |=> !armed_o);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NSRC     = 8,
    parameter int NFAULT   = 5,
    parameter int INT_BASE = 16,
    parameter int VEC_W    = 24,
    localparam int IDX_W   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cyc_end,
    input  logic                 glob_ien,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic                 cfg_en,
    input  logic [LVL_W-1:0]     cfg_lvl,
    input  logic [GRP_W-1:0]     cfg_grp,
    input  logic [NSRC-1:0]      req_set,
    input  logic                 cpu_lvl_we,
    input  logic [LVL_W-1:0]     cpu_lvl_wdata,
    input  logic [NFAULT-1:0]    fault_set,
    input  logic [NFAULT-1:0]    fault_clr,
    input  logic                 sw_trap,
    input  logic [TNUM_W-1:0]    sw_trap_num,
    output logic                 ack,
    output logic [TNUM_W-1:0]    ack_trapno,
    output logic [VEC_W-1:0]     ack_vec,
    output logic [LVL_W-1:0]     ack_lvl,
    output logic [LVL_W-1:0]     cpu_lvl,
    output logic [NSRC-1:0]      req_pend,
    output logic [NFAULT-1:0]    fault_flags
);
    typedef struct packed {
        logic              ack;
        ev_kind_t          kind;
        logic [TNUM_W-1:0] trapno;
        logic [LVL_W-1:0]  lvl;
        logic [LVL_W-1:0]  cpu;
    } st_t;

    st_t st_d, st_q;

    src_cfg_t [NSRC-1:0] src_cfg;
    logic [NSRC-1:0]     req_clr;
    logic                win_valid;
    logic [IDX_W-1:0]    win_idx;
    logic [LVL_W-1:0]    win_lvl;
    logic                flt_armed;
    logic                flt_take;
    logic                sw_ok;

    irq_srcregs #(.NSRC(NSRC), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_en(cfg_en), .cfg_lvl(cfg_lvl), .cfg_grp(cfg_grp),
        .req_set(req_set), .req_clr(req_clr), .cfg_o(src_cfg), .pend_o(req_pend)
    );

    irq_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
        .cfg_i(src_cfg), .pend_i(req_pend),
        .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl)
    );

    irq_faults #(.NFAULT(NFAULT)) u_flt (
        .clk(clk), .rst_n(rst_n), .fault_set(fault_set), .fault_clr(fault_clr),
        .take(flt_take), .flags_o(fault_flags), .armed_o(flt_armed)
    );

    assign sw_ok = sw_trap && !((sw_trap_num >= RSV_LO) && (sw_trap_num <= RSV_HI));

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        req_clr  = '0;
        flt_take = 1'b0;
        if (cpu_lvl_we) st_d.cpu = cpu_lvl_wdata;
        if (cyc_end) begin
            if (flt_armed) begin
                flt_take    = 1'b1;
                st_d.ack    = 1'b1;
                st_d.kind   = EV_FAULT;
                st_d.trapno = FAULT_TNUM;
                st_d.lvl    = TOP_LVL;
                st_d.cpu    = TOP_LVL;
            end else if (sw_ok) begin
                st_d.ack    = 1'b1;
                st_d.kind   = EV_SOFT;
                st_d.trapno = sw_trap_num;
                st_d.lvl    = st_q.cpu;
            end else if (win_valid && glob_ien && (win_lvl > st_q.cpu)) begin
                req_clr[win_idx] = 1'b1;
                st_d.ack    = 1'b1;
                st_d.kind   = EV_IRQ;
                st_d.trapno = TNUM_W'(INT_BASE) + TNUM_W'(win_idx);
                st_d.lvl    = win_lvl;
                st_d.cpu    = win_lvl;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ack: 1'b0, kind: EV_NONE, trapno: '0, lvl: '0, cpu: '0};
        else        st_q <= st_d;
    end

    assign ack        = st_q.ack;
    assign ack_trapno = st_q.trapno;
    assign ack_vec    = {{(VEC_W-TNUM_W-2){1'b0}}, st_q.trapno, 2'b00};
    assign ack_lvl    = st_q.lvl;
    assign cpu_lvl    = st_q.cpu;

    // R3: acknowledges appear only after a boundary
    p_ack_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(cyc_end));
    // R3: an interrupt beats the prior CPU level and needed the global enable
    p_irq_strict_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && st_q.kind == EV_IRQ) |-> ((ack_lvl > $past(cpu_lvl)) && $past(glob_ien)));
    // R4: accepted interrupt level becomes the CPU level
    p_irq_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && st_q.kind == EV_IRQ) |-> (cpu_lvl == ack_lvl));
    // R6: an armed fault is always taken at the boundary
    p_fault_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && flt_armed) |=> (ack && ack_trapno == FAULT_TNUM && cpu_lvl == TOP_LVL));
    // R7: a software trap leaves the CPU level alone
    p_soft_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && sw_ok && !flt_armed && !cpu_lvl_we) |=> $stable(cpu_lvl));
endmodule

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;
    localparam int NS = 6;
    localparam int NF = 5;
    localparam int IB = 16;
    localparam int VW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_end = 0, glob_ien = 0, cfg_we = 0, cfg_en = 0, cpu_lvl_we = 0, sw_trap = 0;
    logic [2:0] cfg_idx = '0;
    logic [3:0] cfg_lvl = '0, cpu_lvl_wdata = '0;
    logic [1:0] cfg_grp = '0;
    logic [NS-1:0] req_set = '0;
    logic [NF-1:0] fault_set = '0, fault_clr = '0;
    logic [6:0] sw_trap_num = '0;
    logic ack;
    logic [6:0] ack_trapno;
    logic [VW-1:0] ack_vec;
    logic [3:0] ack_lvl, cpu_lvl;
    logic [NS-1:0] req_pend;
    logic [NF-1:0] fault_flags;

    int nchk = 0;
    int nerr = 0;
    int ce[NS], cl[NS], cg[NS];

    irq_arbiter #(.NSRC(NS), .NFAULT(NF), .INT_BASE(IB), .VEC_W(VW)) dut (
        .clk(clk), .rst_n(rst_n), .cyc_end(cyc_end), .glob_ien(glob_ien),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_lvl(cfg_lvl),
        .cfg_grp(cfg_grp), .req_set(req_set), .cpu_lvl_we(cpu_lvl_we),
        .cpu_lvl_wdata(cpu_lvl_wdata), .fault_set(fault_set), .fault_clr(fault_clr),
        .sw_trap(sw_trap), .sw_trap_num(sw_trap_num), .ack(ack), .ack_trapno(ack_trapno),
        .ack_vec(ack_vec), .ack_lvl(ack_lvl), .cpu_lvl(cpu_lvl), .req_pend(req_pend),
        .fault_flags(fault_flags)
    );

    always #2 clk = ~clk;

    // entry: {req[5:0], cpu[3:0], ien, exp_ack, exp_idx[2:0]}
    localparam logic [14:0] TBL [8] = '{
        {6'b000011, 4'd0, 1'b1, 1'b1, 3'd1},
        {6'b001111, 4'd0, 1'b1, 1'b1, 3'd2},
        {6'b001100, 4'd5, 1'b1, 1'b0, 3'd0},
        {6'b001100, 4'd4, 1'b1, 1'b1, 3'd2},
        {6'b000011, 4'd0, 1'b0, 1'b0, 3'd0},
        {6'b010000, 4'd0, 1'b1, 1'b0, 3'd0},
        {6'b100001, 4'd0, 1'b1, 1'b1, 3'd0},
        {6'b101000, 4'd2, 1'b1, 1'b1, 3'd3}
    };
    localparam int BE[NS] = '{1, 1, 1, 1, 1, 0};
    localparam int BL[NS] = '{3, 3, 5, 5, 0, 7};
    localparam int BG[NS] = '{1, 2, 0, 0, 3, 0};

    task automatic chk(input string rq, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; cyc_end = 0; glob_ien = 0; cfg_we = 0; cpu_lvl_we = 0; sw_trap = 0;
        req_set = '0; fault_set = '0; fault_clr = '0;
        step(); step();
        rst_n = 1;
        step();
    endtask

    task automatic cfgw(input int i, input int e, input int l, input int g);
        cfg_we = 1; cfg_idx = 3'(i); cfg_en = 1'(e); cfg_lvl = 4'(l); cfg_grp = 2'(g);
        ce[i] = e; cl[i] = l; cg[i] = g;
        step();
        cfg_we = 0;
    endtask

    task automatic setcpu(input int l);
        cpu_lvl_we = 1; cpu_lvl_wdata = 4'(l);
        step();
        cpu_lvl_we = 0;
    endtask

    task automatic raise(input logic [NS-1:0] m);
        req_set = m;
        step();
        req_set = '0;
    endtask

    task automatic boundary();
        cyc_end = 1;
        step();
        cyc_end = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        step();
        do_reset();
        // R1 reset state
        chk("R1 ack", int'(ack), 0);
        chk("R1 cpu_lvl", int'(cpu_lvl), 0);
        chk("R1 req_pend", int'(req_pend), 0);
        chk("R1 fault_flags", int'(fault_flags), 0);

        // table of arbitration cases
        for (int t = 0; t < 8; t++) begin
            logic [NS-1:0] m;
            int idx;
            m = TBL[t][14:9];
            idx = int'(TBL[t][2:0]);
            do_reset();
            for (int i = 0; i < NS; i++) cfgw(i, BE[i], BL[i], BG[i]);
            setcpu(int'(TBL[t][8:5]));
            glob_ien = TBL[t][4];
            raise(m);
            boundary();
            chk("R2 R3 ack", int'(ack), int'(TBL[t][3]));
            if (TBL[t][3]) begin
                chk("R2 R4 trapno", int'(ack_trapno), IB + idx);
                chk("R4 ack_lvl", int'(ack_lvl), BL[idx]);
                chk("R4 cpu_lvl", int'(cpu_lvl), BL[idx]);
                chk("R4 cleared", int'(req_pend), int'(m & ~(6'd1 << idx)));
                chk("R9 vector", int'(ack_vec), (IB + idx) * 4);
            end else begin
                chk("R5 still pending", int'(req_pend), int'(m));
            end
        end

        // R6 fault trap ignores enable and CPU level
        do_reset();
        glob_ien = 0;
        setcpu(15);
        fault_set = 5'b00100; step(); fault_set = '0;
        chk("R6 sticky set", int'(fault_flags), 5'b00100);
        boundary();
        chk("R6 ack", int'(ack), 1);
        chk("R6 trapno", int'(ack_trapno), 'h0A);
        chk("R6 vector", int'(ack_vec), 'h28);
        chk("R6 ack_lvl", int'(ack_lvl), 15);
        chk("R6 cpu_lvl", int'(cpu_lvl), 15);
        chk("R6 flag holds", int'(fault_flags), 5'b00100);
        boundary();
        chk("R6 taken once", int'(ack), 0);
        fault_set = 5'b00001; fault_clr = 5'b00101; step(); fault_set = '0; fault_clr = '0;
        chk("R6 clear vs set", int'(fault_flags), 5'b00001);

        // R7 software traps
        do_reset();
        setcpu(3);
        sw_trap = 1; sw_trap_num = 7'h7F; boundary(); sw_trap = 0;
        chk("R7 ack", int'(ack), 1);
        chk("R7 trapno", int'(ack_trapno), 'h7F);
        chk("R9 top vector", int'(ack_vec), 'h1FC);
        chk("R7 ack_lvl", int'(ack_lvl), 3);
        chk("R7 cpu kept", int'(cpu_lvl), 3);
        for (int n = 'h0A; n <= 'h10; n++) begin
            sw_trap = 1; sw_trap_num = 7'(n); boundary(); sw_trap = 0;
            chk("R7 reserved window", int'(ack), (n >= 'h0B && n <= 'h0F) ? 0 : 1);
        end
        sw_trap = 1; sw_trap_num = 7'h00; boundary(); sw_trap = 0;
        chk("R9 zero vector", int'(ack_vec), 0);

        // R8 precedence at one boundary
        do_reset();
        cfgw(0, 1, 9, 0);
        glob_ien = 1;
        raise(6'b000001);
        fault_set = 5'b10000; step(); fault_set = '0;
        sw_trap = 1; sw_trap_num = 7'h20; boundary(); sw_trap = 0;
        chk("R8 fault first", int'(ack_trapno), 'h0A);
        chk("R8 irq pending", int'(req_pend), 1);
        setcpu(0);
        sw_trap = 1; sw_trap_num = 7'h20; boundary(); sw_trap = 0;
        chk("R8 soft before irq", int'(ack_trapno), 'h20);
        chk("R8 irq still pending", int'(req_pend), 1);
        boundary();
        chk("R8 irq last", int'(ack_trapno), IB);
        chk("R8 cpu", int'(cpu_lvl), 9);

        // R10 direct load versus accept
        do_reset();
        cfgw(0, 1, 6, 0);
        glob_ien = 1;
        raise(6'b000001);
        cpu_lvl_we = 1; cpu_lvl_wdata = 4'd2; boundary(); cpu_lvl_we = 0;
        chk("R10 accept wins", int'(cpu_lvl), 6);
        setcpu(2);
        chk("R10 direct load", int'(cpu_lvl), 2);

        // R4 fresh request at the accept edge
        do_reset();
        cfgw(1, 1, 4, 0);
        glob_ien = 1;
        raise(6'b000010);
        req_set = 6'b000010; boundary(); req_set = '0;
        chk("R4 ack", int'(ack_trapno), IB + 1);
        chk("R4 re-pending", int'(req_pend), 6'b000010);
        step();
        chk("R3 single pulse", int'(ack), 0);

        // random sets against a reference maximum search (R2 R3 R4)
        for (int r = 0; r < 300; r++) begin
            logic [NS-1:0] m;
            int cpu, ien, best, bidx, wl;
            bit found;
            do_reset();
            for (int i = 0; i < NS; i++)
                cfgw(i, int'($urandom_range(0, 3) != 0), int'($urandom_range(0, 15)), int'($urandom_range(0, 3)));
            m = NS'($urandom);
            cpu = int'($urandom_range(0, 12));
            ien = int'($urandom_range(0, 5) != 0);
            setcpu(cpu);
            glob_ien = 1'(ien);
            raise(m);
            boundary();
            found = 0; best = -1; bidx = 0;
            for (int i = 0; i < NS; i++) begin
                if (m[i] && ce[i] != 0 && cl[i] != 0 && (cl[i] * 4 + cg[i]) > best) begin
                    found = 1; best = cl[i] * 4 + cg[i]; bidx = i;
                end
            end
            wl = found ? cl[bidx] : 0;
            if (found && ien != 0 && wl > cpu) begin
                chk("R3 random ack", int'(ack), 1);
                chk("R2 random winner", int'(ack_trapno), IB + bidx);
                chk("R4 random cpu", int'(cpu_lvl), wl);
            end else begin
                chk("R3 random no ack", int'(ack), 0);
                chk("R5 random pending", int'(req_pend), int'(m));
            end
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule